// File: doc/BRIEF.md
# Power-Down Sequencer

This block steps a device into and out of a low-power state in response to an active-low sleep request from a pin. On the way down it gates off the input buffers and raises a global set/reset together, then drops the output-buffer enable a short spacing later. On the way up it reopens the inputs first and releases the global set/reset one cycle later. It re-enables the outputs after the same spacing and raises a ready flag only once a guard interval has passed since set/reset was released. All intervals are clock-cycle parameters.

The request is synchronised and then filtered, so a low pulse shorter than a minimum width has no effect at all. Once entry has begun it always completes before any exit starts. While the inputs are gated off, the forced core-side input bus reads as all zeros. The configuration flags can show that configuration had not finished when sleep was entered. In that case the block raises a one-cycle restart request as it wakes, so the configuration engine can start over.

Top module: `sleep_seq_top`

## Requirements
- R1: The sleep request `sleepReqN` is active low and passes through a two-flop synchroniser before use. After reset the outputs are `inEn`=1, `outEn`=1, `gsr`=0, `ready`=1, `cfgRestart`=0.
- R2: A request is accepted only if it stays low for at least `MIN_WIDTH` consecutive clock cycles. Counting from the first rising edge at which the pin is low, `inEn` falls after edge `MIN_WIDTH`+2. A shorter low pulse leaves every output unchanged.
- R3: On entry, `inEn` falls and `gsr` rises on the same edge, while `outEn` is still high. `outEn` falls `EDGE_GAP` cycles later.
- R4: On exit, `inEn` rises at the third edge after the request returns high. At that point `gsr` is still high and `outEn` is still low. `gsr` falls one cycle later, and `outEn` rises `EDGE_GAP` cycles after `gsr` falls.
- R5: `ready` falls with `inEn` on entry. It rises `GUARD_CYC` cycles after `gsr` falls, and is high only when `inEn` and `outEn` are high and `gsr` is low.
- R6: If the request is released while entry is still in progress, `outEn` still falls before `inEn` rises again.
- R7: If `cfgBusy` is high or `cfgDone` is low at the moment a request is accepted, `cfgRestart` pulses high for exactly one cycle, on the cycle in which `inEn` rises at exit. Otherwise it stays low.
- R8: While `inEn` is low, `coreIn` reads all zeros whatever `padIn` carries. While `inEn` is high, `coreIn` equals `padIn`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sleepReqN | input | 1 | Asynchronous active-low sleep request |
| cfgBusy | input | 1 | Configuration is currently in progress |
| cfgDone | input | 1 | Device has completed configuration |
| padIn | input | PAD_W | Raw input-buffer values |
| coreIn | output | PAD_W | Input values as seen by the core, forced low when gated |
| inEn | output | 1 | Input-buffer enable |
| gsr | output | 1 | Global set/reset |
| outEn | output | 1 | Output-buffer enable |
| ready | output | 1 | Device usable |
| cfgRestart | output | 1 | One-cycle configuration-restart request |

## Verification
Each sequencer state drives a distinct combination of `inEn`, `gsr` and `outEn`. A wrong state therefore shows up at the ports on the very cycle it is entered, as an ordering violation or as an edge that arrives one or more cycles early or late. A fault in the width filter or the phase counter shifts the edge times by whole cycles, or lets a short pulse move the outputs. A mishandled restart flag either drops the one-cycle pulse at the moment the inputs come back or emits one that should not be there.

// File: rtl/sleep_seq_pkg.sv
package sleep_seq_pkg;
  typedef enum logic [2:0] {
    ST_ACTIVE = 3'd0,
    ST_ENTER  = 3'd1,
    ST_DOWN   = 3'd2,
    ST_EXIT   = 3'd3,
    ST_GUARD  = 3'd4
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic cntClr;    // restart the phase counter
    logic cfgLatch;  // capture configuration staleness
    logic cfgClr;    // drop pending restart
  } seqStrobe_t;
endpackage

// File: rtl/sleep_seq_datapath.sv
module sleep_seq_datapath
  import sleep_seq_pkg::*;
#(
  parameter int MIN_WIDTH = 5,
  parameter int EDGE_GAP  = 1,
  parameter int GUARD_CYC = 5,
  parameter int PAD_W     = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sleepReqN,
  input  logic             cfgBusy,
  input  logic             cfgDone,
  input  seqStrobe_t       strobe,
  input  logic             inEn,
  input  logic [PAD_W-1:0] padIn,
  output logic [PAD_W-1:0] coreIn,
  output logic             reqHeld,
  output logic             reqQual,
  output logic             enterDone,
  output logic             outAllowed,
  output logic             guardDone,
  output logic             restartPending
);
  localparam int WideMax = (MIN_WIDTH > GUARD_CYC) ? MIN_WIDTH : GUARD_CYC;
  localparam int CntW    = $clog2(WideMax + EDGE_GAP + 1) + 1;
  localparam logic [CntW-1:0] WidthLast = CntW'(MIN_WIDTH - 1);
  localparam logic [CntW-1:0] GapLast   = CntW'(EDGE_GAP - 1);
  localparam logic [CntW-1:0] GapVal    = CntW'(EDGE_GAP);
  localparam logic [CntW-1:0] GuardLast = CntW'(GUARD_CYC - 1);
  localparam logic [CntW-1:0] CntTop    = {CntW{1'b1}};

  logic [1:0]      syncPipe;
  logic [CntW-1:0] widthCnt;
  logic [CntW-1:0] phaseCnt;

  // two-flop synchroniser, internal polarity active high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncPipe <= 2'b00;
    else       syncPipe <= {syncPipe[0], ~sleepReqN};
  end
  assign reqHeld = syncPipe[1];

  // pulse-width filter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   widthCnt <= '0;
    else if (!reqHeld)           widthCnt <= '0;
    else if (widthCnt < WidthLast) widthCnt <= widthCnt + 1'b1;
  end
  assign reqQual = reqHeld && (widthCnt >= WidthLast);

  // phase counter shared by entry spacing and guard time
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 phaseCnt <= '0;
    else if (strobe.cntClr)    phaseCnt <= '0;
    else if (phaseCnt != CntTop) phaseCnt <= phaseCnt + 1'b1;
  end
  assign enterDone  = (phaseCnt >= GapLast);
  assign outAllowed = (phaseCnt >= GapVal);
  assign guardDone  = (phaseCnt >= GuardLast);

  // configuration-restart bookkeeping
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                restartPending <= 1'b0;
    else if (strobe.cfgLatch) restartPending <= cfgBusy || !cfgDone;
    else if (strobe.cfgClr)   restartPending <= 1'b0;
  end

  // input forcing
  assign coreIn = inEn ? padIn : '0;
endmodule

// File: rtl/sleep_seq_ctrl.sv
module sleep_seq_ctrl
  import sleep_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqHeld,
  input  logic       reqQual,
  input  logic       enterDone,
  input  logic       outAllowed,
  input  logic       guardDone,
  input  logic       restartPending,
  output seqStrobe_t strobe,
  output logic       inEn,
  output logic       gsr,
  output logic       outEn,
  output logic       ready,
  output logic       cfgRestart
);
  seqState_t state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_ACTIVE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_ACTIVE: if (reqQual)   stateNext = ST_ENTER;
      ST_ENTER:  if (enterDone) stateNext = ST_DOWN;
      ST_DOWN:   if (!reqHeld)  stateNext = ST_EXIT;
      ST_EXIT:                  stateNext = ST_GUARD;
      ST_GUARD:  if (guardDone) stateNext = ST_ACTIVE;
      default:                  stateNext = ST_ACTIVE;
    endcase
  end

  always_comb begin
    strobe.cntClr   = (stateNext != state);
    strobe.cfgLatch = (state == ST_ACTIVE) && reqQual;
    strobe.cfgClr   = (state == ST_EXIT);
  end

  assign inEn       = (state == ST_ACTIVE) || (state == ST_EXIT) || (state == ST_GUARD);
  assign gsr        = (state == ST_ENTER) || (state == ST_DOWN) || (state == ST_EXIT);
  assign outEn      = (state == ST_ACTIVE) || (state == ST_ENTER) ||
                      ((state == ST_GUARD) && outAllowed);
  assign ready      = (state == ST_ACTIVE);
  assign cfgRestart = (state == ST_EXIT) && restartPending;
endmodule

// File: rtl/sleep_seq_top.sv
module sleep_seq_top
  import sleep_seq_pkg::*;
#(
  parameter int MIN_WIDTH = 5,
  parameter int EDGE_GAP  = 1,
  parameter int GUARD_CYC = 5,
  parameter int PAD_W     = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sleepReqN,
  input  logic             cfgBusy,
  input  logic             cfgDone,
  input  logic [PAD_W-1:0] padIn,
  output logic [PAD_W-1:0] coreIn,
  output logic             inEn,
  output logic             gsr,
  output logic             outEn,
  output logic             ready,
  output logic             cfgRestart
);
  seqStrobe_t strobe;
  logic reqHeld, reqQual, enterDone, outAllowed, guardDone, restartPending;

  sleep_seq_datapath #(
    .MIN_WIDTH(MIN_WIDTH), .EDGE_GAP(EDGE_GAP),
    .GUARD_CYC(GUARD_CYC), .PAD_W(PAD_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .sleepReqN(sleepReqN),
    .cfgBusy(cfgBusy), .cfgDone(cfgDone), .strobe(strobe),
    .inEn(inEn), .padIn(padIn), .coreIn(coreIn),
    .reqHeld(reqHeld), .reqQual(reqQual), .enterDone(enterDone),
    .outAllowed(outAllowed), .guardDone(guardDone),
    .restartPending(restartPending)
  );

  sleep_seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqHeld(reqHeld), .reqQual(reqQual),
    .enterDone(enterDone), .outAllowed(outAllowed), .guardDone(guardDone),
    .restartPending(restartPending), .strobe(strobe),
    .inEn(inEn), .gsr(gsr), .outEn(outEn), .ready(ready),
    .cfgRestart(cfgRestart)
  );
endmodule

// File: rtl/sleep_seq_checker.sv
module sleep_seq_checker (
  input logic clk,
  input logic rstN,
  input logic inEn,
  input logic gsr,
  input logic outEn,
  input logic ready,
  input logic cfgRestart
);
  p_entry_order_r3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(inEn) |-> (gsr && outEn));

  p_out_late_r3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(outEn) |-> (!inEn && gsr && $past(!inEn)));

  p_exit_order_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(inEn) |-> (gsr && !outEn));

  p_gsr_release_r4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(gsr) |-> (inEn && $past(inEn) && !outEn));

  p_ready_safe_r5: assert property (@(posedge clk) disable iff (!rstN)
    ready |-> (inEn && outEn && !gsr));

  p_restart_edge_r7: assert property (@(posedge clk) disable iff (!rstN)
    cfgRestart |-> $rose(inEn));

  p_restart_single_r7: assert property (@(posedge clk) disable iff (!rstN)
    cfgRestart |=> !cfgRestart);
endmodule

bind sleep_seq_top sleep_seq_checker u_chk (
  .clk(clk), .rstN(rstN), .inEn(inEn), .gsr(gsr),
  .outEn(outEn), .ready(ready), .cfgRestart(cfgRestart)
);

// File: tb/sim_sleep_seq_top.sv
module sim_sleep_seq_top;
  localparam int CLK_PERIOD = 10;
  localparam int MIN_W  = 5;
  localparam int GAP    = 1;
  localparam int GUARD  = 5;
  localparam int PW     = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sleepReqN = 1'b1;
  logic cfgBusy = 1'b0;
  logic cfgDone = 1'b1;
  logic [PW-1:0] padIn = '0;
  logic [PW-1:0] coreIn;
  logic inEn, gsr, outEn, ready, cfgRestart;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  // first edge index at which each output changed in the last window
  int eInFall, eInRise, eGsrRise, eGsrFall, eOutFall, eOutRise;
  int eRdyFall, eRdyRise, eRst, nRst;
  bit anyChange;

  always #(CLK_PERIOD/2) clk = ~clk;

  sleep_seq_top #(.MIN_WIDTH(MIN_W), .EDGE_GAP(GAP), .GUARD_CYC(GUARD), .PAD_W(PW)) u0 (
    .clk(clk), .rstN(rstN), .sleepReqN(sleepReqN), .cfgBusy(cfgBusy),
    .cfgDone(cfgDone), .padIn(padIn), .coreIn(coreIn), .inEn(inEn),
    .gsr(gsr), .outEn(outEn), .ready(ready), .cfgRestart(cfgRestart)
  );

  task automatic checkInt(input int act, input int exp, input string what);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  // watch n edges, sampling shortly after each rising edge
  task automatic watch(input int n);
    logic pIn, pGsr, pOut, pRdy;
    eInFall = -1; eInRise = -1; eGsrRise = -1; eGsrFall = -1;
    eOutFall = -1; eOutRise = -1; eRdyFall = -1; eRdyRise = -1;
    eRst = -1; nRst = 0; anyChange = 1'b0;
    pIn = inEn; pGsr = gsr; pOut = outEn; pRdy = ready;
    for (int e = 1; e <= n; e++) begin
      @(posedge clk); #1;
      if (pIn && !inEn && eInFall < 0) eInFall = e;
      if (!pIn && inEn && eInRise < 0) eInRise = e;
      if (!pGsr && gsr && eGsrRise < 0) eGsrRise = e;
      if (pGsr && !gsr && eGsrFall < 0) eGsrFall = e;
      if (pOut && !outEn && eOutFall < 0) eOutFall = e;
      if (!pOut && outEn && eOutRise < 0) eOutRise = e;
      if (pRdy && !ready && eRdyFall < 0) eRdyFall = e;
      if (!pRdy && ready && eRdyRise < 0) eRdyRise = e;
      if (cfgRestart) begin nRst++; if (eRst < 0) eRst = e; end
      if (inEn != pIn || gsr != pGsr || outEn != pOut || ready != pRdy || cfgRestart)
        anyChange = 1'b1;
      pIn = inEn; pGsr = gsr; pOut = outEn; pRdy = ready;
    end
  endtask

  task automatic testReset();
    @(negedge clk);
    checkInt(inEn, 1, "R1 inEn after reset");
    checkInt(outEn, 1, "R1 outEn after reset");
    checkInt(gsr, 0, "R1 gsr after reset");
    checkInt(ready, 1, "R1 ready after reset");
    checkInt(cfgRestart, 0, "R1 cfgRestart after reset");
  endtask

  task automatic testShortPulse();
    @(negedge clk);
    padIn = 8'h5A;
    sleepReqN = 1'b0;
    fork
      begin repeat (MIN_W - 1) @(negedge clk); sleepReqN = 1'b1; end
      watch(20);
    join
    checkInt(anyChange, 0, "R2 short pulse leaves outputs unchanged");
    @(negedge clk);
    checkInt(coreIn, 8'h5A, "R8 coreIn follows padIn when enabled");
  endtask

  task automatic testFullCycle(input bit stale);
    @(negedge clk);
    cfgDone = !stale;
    cfgBusy = stale;
    padIn = 8'hFF;
    sleepReqN = 1'b0;
    watch(15);
    checkInt(eInFall, MIN_W + 2, "R2 inEn fall edge after request");
    checkInt(eGsrRise, MIN_W + 2, "R3 gsr rises with inEn fall");
    checkInt(eOutFall, MIN_W + 2 + GAP, "R3 outEn falls after spacing");
    checkInt(eRdyFall, MIN_W + 2, "R5 ready falls on entry");
    @(negedge clk);
    checkInt(coreIn, 0, "R8 coreIn forced low while gated");
    cfgDone = 1'b1;
    cfgBusy = 1'b0;
    sleepReqN = 1'b1;
    watch(15);
    checkInt(eInRise, 3, "R4 inEn rises third edge after release");
    checkInt(eGsrFall, 4, "R4 gsr falls one cycle after inEn");
    checkInt(eOutRise, 4 + GAP, "R4 outEn rises after spacing");
    checkInt(eRdyRise, 4 + GUARD, "R5 ready after guard time");
    checkInt(nRst, stale ? 1 : 0, "R7 restart pulse count");
    if (stale) checkInt(eRst, 3, "R7 restart pulse aligned with inEn rise");
    @(negedge clk);
    checkInt(coreIn, 8'hFF, "R8 coreIn restored");
  endtask

  task automatic testReleaseDuringEntry();
    @(negedge clk);
    sleepReqN = 1'b0;
    fork
      begin repeat (MIN_W) @(negedge clk); sleepReqN = 1'b1; end
      watch(25);
    join
    checkInt(eInFall, MIN_W + 2, "R2 minimum-width pulse accepted");
    checkInt(eOutFall, MIN_W + 2 + GAP, "R6 entry completes with outEn fall");
    checkInt(eInRise, MIN_W + 3 + GAP, "R6 exit begins after entry");
    checkInt(eRdyRise, MIN_W + 4 + GAP + GUARD, "R6 ready after guard");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testShortPulse();
    testFullCycle(1'b0);
    testFullCycle(1'b1);
    testReleaseDuringEntry();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule